// File: doc/BRIEF.md
# SPI Master Controller with Transmit and Receive Queues

This block is a serial peripheral interface master driven from a simple 32-bit register port. Software programs the frame size (4, 8 or 16 bits), the clock polarity and phase, an even clock divider and one of three transfer modes. It then pushes words into a 32-entry transmit queue and pops received words from a 32-entry receive queue. A shift engine turns queued words into serial frames, most significant bit first, while two active-low chip-select outputs follow a software-owned select register.

In full-duplex mode every transmitted frame also captures one received frame. Transmit-only mode drops what comes back on the input line. Receive-only mode needs no transmit data: it clocks a programmed number of frames, holding the output line low. Serial activity needs the enable register to be set. Clearing it stops the engine at once and leaves both queues as they are.

The engine is a three-state machine. ENG_IDLE waits for work. From there it moves to ENG_HALF_A when enabled and a frame can begin: a transmit word is present, or a receive-only frame remains, and the receive queue has room whenever data will be kept. ENG_HALF_A is the first half of a bit; on its timer tick the input line is sampled and the machine goes to ENG_HALF_B. ENG_HALF_B is the second half of the bit. On its tick the output shifts and the machine returns to ENG_HALF_A, or to ENG_IDLE after the last bit, which also stores the frame. Clearing the enable moves either half state straight to ENG_IDLE.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register reads 0x0C, both fill levels read 0, cs_n is 2'b11 and sclk is low.
- R2: The frame-size field (control word bits [1:0]) selects 4 bits for 0, 8 bits for 1 and 16 bits for 2; frames go out most significant bit first, and received words are right-justified with the unused upper bits zero.
- R3: Control bit 7 sets the sclk idle level and control bit 6 selects sampling on the leading (0) or trailing (1) edge; a looped-back word is received intact in all four combinations, and sclk rests at the idle level between transfers.
- R4: The divider register (offset 0x10) holds the sclk period in core clocks; bit 0 always reads 0, and each sclk half lasts divider/2 cycles, with 0 behaving as 2.
- R5: In full-duplex mode (control bits [19:18] = 0) each transmit word yields exactly one received word, in order; the engine stays idle (busy low) while the transmit queue is empty and never pushes into a full receive queue.
- R6: In transmit-only mode (bits [19:18] = 1) frames are sent but the receive queue level does not change.
- R7: In receive-only mode (bits [19:18] = 2) the engine clocks exactly (offset 0x04 value + 1) frames with mosi held low, stores each one and then stops.
- R8: With the enable register (offset 0x08) at 0 no sclk edges occur and busy is low; queued words stay in place and are sent once the enable is set.
- R9: Bit i of the select register (offset 0x0C) drives cs_n[i] low when set.
- R10: The status register (offset 0x24) holds busy in bit 0, transmit full in bit 1, transmit empty in bit 2, receive empty in bit 3 and receive full in bit 4.
- R11: Each queue holds 32 words; writes to 0x400 push, reads of 0x800 pop, offsets 0x1C and 0x20 give the fill levels, a push into a full queue is dropped and a pop of an empty queue returns 0.
- R12: The raw-event register (offset 0x34) sets bit 0 on a dropped push, bit 1 on an empty pop and bit 2 on each finished frame; writing ones to the low seven bits of offset 0x38 clears the matching bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at receive-data offset) |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
A wrong phase in the state machine shows up within one frame as a corrupted looped-back word, or as a count of active sclk cycles that differs from frame bits times half period. A lost or stuck receive-only frame counter shows in the receive fill level one frame time after the transfer should end. Queue pointer faults appear at the next level read or pop, because levels, order and the empty-pop value of zero are all visible at the register port. A missing enable gate shows as sclk activity during a window of fifty disabled cycles.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int REG_AW  = 12;
    localparam int FRAME_W = 16;

    localparam logic [REG_AW-1:0] A_CTRL0  = 12'h000;
    localparam logic [REG_AW-1:0] A_CTRL1  = 12'h004;
    localparam logic [REG_AW-1:0] A_ENABLE = 12'h008;
    localparam logic [REG_AW-1:0] A_SLVSEL = 12'h00C;
    localparam logic [REG_AW-1:0] A_DIV    = 12'h010;
    localparam logic [REG_AW-1:0] A_TXLVL  = 12'h01C;
    localparam logic [REG_AW-1:0] A_RXLVL  = 12'h020;
    localparam logic [REG_AW-1:0] A_STATUS = 12'h024;
    localparam logic [REG_AW-1:0] A_RAW    = 12'h034;
    localparam logic [REG_AW-1:0] A_ICLR   = 12'h038;
    localparam logic [REG_AW-1:0] A_TXDATA = 12'h400;
    localparam logic [REG_AW-1:0] A_RXDATA = 12'h800;

    typedef enum logic [1:0] {
        XFER_DUPLEX  = 2'd0,
        XFER_TX_ONLY = 2'd1,
        XFER_RX_ONLY = 2'd2,
        XFER_RSVD    = 2'd3
    } xfer_mode_t;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_HALF_A = 2'd1,
        ENG_HALF_B = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R11
    fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R11
    fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  xfer_mode_t         mode,
    input  logic               cpol,
    input  logic               cpha,
    input  logic [1:0]         fsz,
    input  logic [DIV_W-1:0]   div,
    input  logic [CNT_W-1:0]   ro_last,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    output logic               busy,
    output logic               frame_done,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso
);
    localparam int HW = DIV_W - 1;
    localparam int BW = $clog2(FRAME_W);

    eng_state_t          state, nxt;
    logic [HW-1:0]       tmr, half_eff;
    logic [BW-1:0]       bit_cnt, last_bit;
    logic [FRAME_W-1:0]  tx_sh, rx_sh, mask, tx_aligned;
    logic [CNT_W-1:0]    frm_cnt;
    logic                ro_done, tick, start_dx, start_ro, frame_end;

    assign half_eff = (div[DIV_W-1:1] == '0) ? HW'(1) : div[DIV_W-1:1];
    assign tick     = (tmr == half_eff - 1'b1);

    always_comb begin
        unique case (fsz)
            2'd0: begin
                last_bit   = BW'(3);
                mask       = FRAME_W'(16'h000F);
                tx_aligned = {tx_data[3:0], 12'h000};
            end
            2'd1: begin
                last_bit   = BW'(7);
                mask       = FRAME_W'(16'h00FF);
                tx_aligned = {tx_data[7:0], 8'h00};
            end
            default: begin
                last_bit   = BW'(15);
                mask       = FRAME_W'(16'hFFFF);
                tx_aligned = tx_data;
            end
        endcase
    end

    assign start_dx = en && (mode != XFER_RX_ONLY) && !tx_empty &&
                      ((mode == XFER_TX_ONLY) || !rx_full);
    assign start_ro = en && (mode == XFER_RX_ONLY) && !ro_done && !rx_full;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:   if (start_dx || start_ro) nxt = ENG_HALF_A;
            ENG_HALF_A: if (!en) nxt = ENG_IDLE;
                        else if (tick) nxt = ENG_HALF_B;
            ENG_HALF_B: if (!en) nxt = ENG_IDLE;
                        else if (tick) nxt = (bit_cnt == '0) ? ENG_IDLE : ENG_HALF_A;
            default:    nxt = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    assign frame_end  = (state == ENG_HALF_B) && en && tick && (bit_cnt == '0);
    assign tx_pop     = (state == ENG_IDLE) && start_dx;
    assign rx_push    = frame_end && (mode != XFER_TX_ONLY);
    assign frame_done = frame_end;
    assign rx_data    = rx_sh & mask;
    assign busy       = (state != ENG_IDLE);
    assign mosi       = tx_sh[FRAME_W-1];

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            frm_cnt <= '0;
            ro_done <= 1'b0;
        end else begin
            tmr <= ((state == ENG_IDLE) || tick) ? '0 : tmr + 1'b1;
            unique case (state)
                ENG_IDLE: if (start_dx || start_ro) begin
                    tx_sh   <= start_dx ? tx_aligned : '0;
                    bit_cnt <= last_bit;
                end
                ENG_HALF_A: if (tick) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                ENG_HALF_B: if (tick) begin
                    tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt - 1'b1;
                end
                default: ;
            endcase
            if (!en) begin
                frm_cnt <= '0;
                ro_done <= 1'b0;
            end else if (frame_end && (mode == XFER_RX_ONLY)) begin
                if (frm_cnt == ro_last) ro_done <= 1'b1;
                else                    frm_cnt <= frm_cnt + 1'b1;
            end
        end
    end

    // output process: serial clock follows the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk <= 1'b0;
        else begin
            unique case (nxt)
                ENG_HALF_A: sclk <= cpol ^ cpha;
                ENG_HALF_B: sclk <= cpol ^ ~cpha;
                default:    sclk <= cpol;
            endcase
        end
    end

    // R8
    engine_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    // R3
    sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 16,
    parameter int CS_NUM = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_NUM-1:0] cs_n
);
    localparam int LW = $clog2(DEPTH+1);

    logic [1:0]         fsz_q;
    logic               cpol_q, cpha_q, en_q;
    xfer_mode_t         mode_q;
    logic [CNT_W-1:0]   ctrl1_q;
    logic [CS_NUM-1:0]  sel_q;
    logic [DIV_W-1:0]   div_q;
    logic [2:0]         raw_q;

    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
    logic [LW-1:0]      tx_lvl, rx_lvl;
    logic               busy, frame_done;
    logic [4:0]         status;

    assign tx_push = reg_wr && (reg_addr == A_TXDATA);
    assign rx_pop  = reg_rd && (reg_addr == A_RXDATA);
    assign status  = {rx_full, rx_empty, tx_empty, tx_full, busy};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsz_q   <= 2'd1;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            mode_q  <= XFER_DUPLEX;
            ctrl1_q <= '0;
            en_q    <= 1'b0;
            sel_q   <= '0;
            div_q   <= DIV_W'(2);
            raw_q   <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CTRL0: begin
                        fsz_q  <= reg_wdata[1:0];
                        cpha_q <= reg_wdata[6];
                        cpol_q <= reg_wdata[7];
                        mode_q <= xfer_mode_t'(reg_wdata[19:18]);
                    end
                    A_CTRL1:  ctrl1_q <= reg_wdata[CNT_W-1:0];
                    A_ENABLE: en_q    <= reg_wdata[0];
                    A_SLVSEL: sel_q   <= reg_wdata[CS_NUM-1:0];
                    A_DIV:    div_q   <= {reg_wdata[DIV_W-1:1], 1'b0};
                    A_ICLR:   raw_q   <= raw_q & ~reg_wdata[2:0];
                    default: ;
                endcase
            end
            if (tx_push && tx_full)   raw_q[0] <= 1'b1;
            if (rx_pop && rx_empty)   raw_q[1] <= 1'b1;
            if (frame_done)           raw_q[2] <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL0: begin
                reg_rdata[1:0]   = fsz_q;
                reg_rdata[6]     = cpha_q;
                reg_rdata[7]     = cpol_q;
                reg_rdata[19:18] = mode_q;
            end
            A_CTRL1:  reg_rdata = 32'(ctrl1_q);
            A_ENABLE: reg_rdata = 32'(en_q);
            A_SLVSEL: reg_rdata = 32'(sel_q);
            A_DIV:    reg_rdata = 32'(div_q);
            A_TXLVL:  reg_rdata = 32'(tx_lvl);
            A_RXLVL:  reg_rdata = 32'(rx_lvl);
            A_STATUS: reg_rdata = 32'(status);
            A_RAW:    reg_rdata = 32'(raw_q);
            A_RXDATA: reg_rdata = 32'(rx_head);
            default:  reg_rdata = '0;
        endcase
    end

    for (genvar gi = 0; gi < CS_NUM; gi++) begin : g_cs
        assign cs_n[gi] = ~sel_q[gi];
    end

    spim_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .head(tx_head), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q),
        .cpol(cpol_q), .cpha(cpha_q), .fsz(fsz_q), .div(div_q),
        .ro_last(ctrl1_q), .tx_empty(tx_empty), .tx_data(tx_head),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
        .rx_data(rx_word), .busy(busy), .frame_done(frame_done),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // R5
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R6
    tx_only_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XFER_TX_ONLY && $stable(mode_q) && !rx_pop) |=> $stable(rx_lvl));
endmodule

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [1:0]  cs_n;

    logic        loop_en = 1'b1;
    logic        miso_fix = 1'b0;
    assign miso = loop_en ? mosi : miso_fix;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // monitors
    logic        cpol_cur = 1'b0;
    logic        mon_clr = 1'b0;
    int          act_cnt = 0;
    logic        mosi_hi = 1'b0;
    logic [15:0] cap = '0;

    always @(negedge clk) begin
        if (mon_clr) begin
            act_cnt <= 0;
            mosi_hi <= 1'b0;
        end else begin
            if (sclk != cpol_cur) act_cnt <= act_cnt + 1;
            if (mosi) mosi_hi <= 1'b1;
        end
    end

    always @(posedge sclk) cap <= {cap[14:0], mosi};

    // bits [31:30] frame size, 29 cpol, 28 cpha, [23:16] divider, [15:0] data
    localparam logic [31:0] VEC [8] = '{
        32'h4002_00A5, 32'h5004_003C, 32'h6004_00C3, 32'h7006_0081,
        32'h0002_00F9, 32'hB002_BEEF, 32'h8005_1234, 32'h4000_005A
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] st;
        bit ok = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 5000 && !ok; k++) begin
            rd(12'h024, st);
            if ((st & 32'h5) == 32'h4) ok = 1'b1;
        end
        if (!ok) chk({req, " completion"}, 32'd0, 32'd1);
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 status layout
        rd(12'h024, d); chk("R1 status", d, 32'h0C);
        rd(12'h01C, d); chk("R1 tx level", d, 0);
        rd(12'h020, d); chk("R1 rx level", d, 0);
        chk("R1 cs_n", 32'(cs_n), 32'h3);
        chk("R1 sclk", 32'(sclk), 0);

        // R9 chip selects
        wr(12'h00C, 32'h1); chk("R9 cs0", 32'(cs_n), 32'h2);
        wr(12'h00C, 32'h2); chk("R9 cs1", 32'(cs_n), 32'h1);
        wr(12'h00C, 32'h0);

        // vector loop: full-duplex loopback in each mode, size and divider
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  fsz;
            logic [7:0]  dv;
            logic [15:0] dat, msk;
            int          nb, hf;
            fsz = VEC[v][31:30];
            dv  = VEC[v][23:16];
            dat = VEC[v][15:0];
            nb  = (fsz == 0) ? 4 : (fsz == 1) ? 8 : 16;
            msk = (fsz == 0) ? 16'h000F : (fsz == 1) ? 16'h00FF : 16'hFFFF;
            hf  = ((dv & 8'hFE) >> 1);
            if (hf == 0) hf = 1;
            wr(12'h008, 0);
            wr(12'h000, {24'h0, VEC[v][29], VEC[v][28], 4'h0, fsz});
            wr(12'h010, 32'(dv));
            rd(12'h010, d); chk("R4 divider even readback", d, 32'(dv & 8'hFE));
            cpol_cur = VEC[v][29];
            repeat (2) @(negedge clk);
            chk("R3 idle level", 32'(sclk), 32'(VEC[v][29]));
            clear_mon();
            wr(12'h400, 32'(dat));
            wr(12'h008, 1);
            wait_done("R5 vector");
            chk("R4 active sclk cycles", 32'(act_cnt), 32'(nb * hf));
            rd(12'h800, d); chk("R2 R3 loopback word", d, 32'(dat & msk));
            chk("R3 idle after transfer", 32'(sclk), 32'(VEC[v][29]));
        end

        // R5 several words, order and idle
        wr(12'h008, 0);
        wr(12'h000, 32'h1); cpol_cur = 1'b0;
        wr(12'h010, 2);
        wr(12'h008, 1);
        wr(12'h400, 32'h11); wr(12'h400, 32'h22); wr(12'h400, 32'h33);
        wait_done("R5 multi");
        rd(12'h020, d); chk("R5 rx level", d, 3);
        rd(12'h800, d); chk("R5 first", d, 32'h11);
        rd(12'h800, d); chk("R5 second", d, 32'h22);
        rd(12'h800, d); chk("R5 third", d, 32'h33);
        rd(12'h024, d); chk("R5 R10 idle status", d, 32'h0C);

        // R6 transmit-only, R2 bit order on the wire
        wr(12'h000, 32'h0004_0001);
        wr(12'h400, 32'hB2);
        wait_done("R6");
        rd(12'h020, d); chk("R6 rx level unchanged", d, 0);
        chk("R2 msb first", 32'(cap[7:0]), 32'hB2);

        // R7 receive-only with 5 frames
        wr(12'h008, 0);
        loop_en = 1'b0; miso_fix = 1'b1;
        wr(12'h000, 32'h0008_0001);
        wr(12'h004, 4);
        clear_mon();
        wr(12'h008, 1);
        repeat (300) @(negedge clk);
        rd(12'h020, d); chk("R7 frame count", d, 5);
        chk("R7 mosi low", 32'(mosi_hi), 0);
        rd(12'h024, d); chk("R7 stopped", d & 32'h1, 0);
        wr(12'h008, 0);
        rd(12'h020, d); chk("R8 rx kept while disabled", d, 5);
        rd(12'h800, d); chk("R7 data", d, 32'hFF);
        for (int k = 0; k < 4; k++) rd(12'h800, d);
        loop_en = 1'b1;

        // R8 disabled gate
        wr(12'h000, 32'h1);
        wr(12'h400, 32'h77);
        clear_mon();
        repeat (50) @(negedge clk);
        chk("R8 no sclk while disabled", 32'(act_cnt), 0);
        rd(12'h01C, d); chk("R8 tx kept", d, 1);
        wr(12'h008, 1);
        wait_done("R8");
        rd(12'h800, d); chk("R8 sent after enable", d, 32'h77);

        // R12 raw events and clear
        rd(12'h034, d); chk("R12 frame done bit", d & 32'h4, 32'h4);
        wr(12'h038, 32'h7F);
        rd(12'h034, d); chk("R12 cleared", d, 0);

        // R11 depth, overflow drop, empty pop
        wr(12'h008, 0);
        for (int k = 0; k < 33; k++) wr(12'h400, 32'(k));
        rd(12'h01C, d); chk("R11 tx level at depth", d, 32);
        rd(12'h024, d); chk("R10 full status", d, 32'h0A);
        rd(12'h034, d); chk("R12 dropped push", d, 32'h1);
        wr(12'h038, 32'h1);
        rd(12'h034, d); chk("R12 clear bit0", d, 0);
        rd(12'h800, d); chk("R11 empty pop value", d, 0);
        rd(12'h020, d); chk("R11 rx level after empty pop", d, 0);
        rd(12'h034, d); chk("R12 empty pop", d, 32'h2);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule